// File: doc/BRIEF.md
# Randomized Link-Recovery Reset Scheduler

This block supervises the link of a single-speed Ethernet PHY. It samples a link-status input only at scheduled poll instants, which are counted in millisecond ticks. While the link is up, polls come at a fixed interval. When a poll finds the link down, the block pulses a hardware reset to the PHY. It then waits for the management interface to become usable and for the PHY to stabilise, and then requests that the master/slave role be re-applied. Once the role is restored, the next poll is scheduled after a delay drawn pseudo-randomly from a bounded range.

The random down-state delay keeps two link partners that run identical supervisors from resetting in lockstep, where neither side would ever see the other. The reported speed/duplex validity follows the last poll: it is asserted for gigabit full duplex only after a poll sees the link up. At every other time it reads as unknown.

Top module: `lrs_link_supervisor`

## Requirements
- R1: A poll that finds the link up schedules the next poll exactly UP_MS ticks later, counting the ticks sampled on the clock edges after the poll edge.
- R2: After the role-restore handshake, the next poll comes DOWN_MIN_MS to DOWN_MAX_MS ticks later, both ends included. The delay comes from a free-running nonzero 16-bit LFSR, so successive down delays differ.
- R3: A poll delay is never below one tick. After reset is released, the first poll comes exactly max(DOWN_MIN_MS,1) ticks later.
- R4: A poll that finds the link down raises phy_rst_o for exactly one cycle, in the same cycle as poll_o. phy_rst_o is never high at any other time.
- R5: role_req_o rises exactly MDC_MS+1+SETTLE_MS ticks after the reset pulse. Ticks on the cycle right after the pulse are not counted. This guarantees at least MDC_MS ms of management quiet followed by SETTLE_MS ms of settling.
- R6: role_req_o stays high until role_done_i is sampled high, and falls on the next cycle. role_done_i has no effect while no request is pending.
- R7: speed_gbit_o and duplex_full_o change only in a poll cycle, where both take the link value sampled by that poll. Link changes between polls are ignored.
- R8: poll_o is a single-cycle pulse at each expiry. No poll occurs during the reset/settle/restore sequence.
- R9: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| link_up_i | input | 1 | PHY link status, sampled only at polls |
| role_done_i | input | 1 | Role restore finished |
| phy_rst_o | output | 1 | One-cycle hardware reset pulse to the PHY |
| role_req_o | output | 1 | Request to re-apply master/slave role |
| poll_o | output | 1 | One-cycle pulse at each poll instant |
| speed_gbit_o | output | 1 | Speed reported as 1000 Mb/s (0 = unknown) |
| duplex_full_o | output | 1 | Duplex reported as full (0 = unknown) |

## Verification
The assertions take only a few things for granted about the inputs. A tick may arrive on any cycle. The up interval must exceed one tick, or two polls could fall on back-to-back cycles. Nothing is assumed about role_done_i, which may be high outside a request. The stimulus keeps within this by drawing ticks as sparse random one-cycle pulses, using an up interval well above one tick, and asserting role_done_i at random regardless of the request. It also runs phases with the link steady up, toggling at random, and stuck down, so that many randomized down delays are observed.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [2:0] {
    ST_UP_WAIT,
    ST_DOWN_RESET,
    ST_MDC_WAIT,
    ST_SETTLE,
    ST_RESTORE_ROLE,
    ST_DOWN_WAIT
  } lrs_state_e;

  function automatic int lrs_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lrs_lfsr.sv
module lrs_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] rnd_o
);
  logic [W-1:0] lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {1'b0, lfsr_q[W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
  end

  assign rnd_o = lfsr_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);  // R2
  AST_LFSR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> lfsr_q != $past(lfsr_q));  // R2
endmodule

// File: rtl/lrs_delay_pick.sv
module lrs_delay_pick #(
  parameter int RW     = 16,
  parameter int CW     = 10,
  parameter int MIN_MS = 100,
  parameter int MAX_MS = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] rnd_i,
  output logic [CW-1:0] delay_o
);
  localparam int SPAN = (MAX_MS > MIN_MS) ? MAX_MS - MIN_MS : 0;
  localparam int SW   = $clog2(SPAN + 2);
  localparam int PW   = RW + SW;
  localparam int LO   = (MIN_MS < 1) ? 1 : MIN_MS;
  localparam int HI   = (MAX_MS < LO) ? LO : MAX_MS;

  logic [PW-1:0] prod;
  logic [SW-1:0] off;
  logic [CW-1:0] sum;

  // scale rnd into 0..SPAN without a divider
  always_comb begin
    prod = PW'(rnd_i) * PW'(SPAN + 1);
    off  = prod[PW-1:RW];
    sum  = CW'(MIN_MS) + CW'(off);
    delay_o = (sum == '0) ? CW'(1) : sum;
  end

  AST_DELAY_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_o >= CW'(LO));  // R3
  AST_DELAY_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_o <= CW'(HI));  // R2
endmodule

// File: rtl/lrs_tick_timer.sv
module lrs_tick_timer #(
  parameter int CW      = 10,
  parameter int RST_VAL = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= CW'(RST_VAL);
    else if (load_i)                  cnt_q <= val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = tick_i && (cnt_q == CW'(1));

  AST_TIMER_SPENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !load_i |=> cnt_q == '0);  // R8
  AST_TIMER_NO_LOAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> val_i != '0);  // R3
endmodule

// File: rtl/lrs_fsm.sv
module lrs_fsm
  import lrs_pkg::*;
#(
  parameter int CW        = 10,
  parameter int UP_TICKS  = 1000,
  parameter int MDC_TICKS = 2,
  parameter int SET_TICKS = 600
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          expire_i,
  input  logic          link_up_i,
  input  logic          role_done_i,
  input  logic [CW-1:0] rand_delay_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          poll_o,
  output logic          phy_rst_o,
  output logic          role_req_o,
  output logic          link_ok_o
);
  lrs_state_e state_q, state_d;
  logic       poll_q, poll_d;
  logic       link_q, link_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    poll_d     = 1'b0;
    link_d     = link_q;
    case (state_q)
      ST_UP_WAIT, ST_DOWN_WAIT: begin
        if (expire_i) begin
          poll_d = 1'b1;
          link_d = link_up_i;
          if (link_up_i) begin
            state_d    = ST_UP_WAIT;
            load_o     = 1'b1;
            load_val_o = CW'(UP_TICKS);
          end else begin
            state_d = ST_DOWN_RESET;
          end
        end
      end
      ST_DOWN_RESET: begin
        state_d    = ST_MDC_WAIT;
        load_o     = 1'b1;
        load_val_o = CW'(MDC_TICKS);
      end
      ST_MDC_WAIT: begin
        if (expire_i) begin
          state_d    = ST_SETTLE;
          load_o     = 1'b1;
          load_val_o = CW'(SET_TICKS);
        end
      end
      ST_SETTLE: begin
        if (expire_i) state_d = ST_RESTORE_ROLE;
      end
      ST_RESTORE_ROLE: begin
        if (role_done_i) begin
          state_d    = ST_DOWN_WAIT;
          load_o     = 1'b1;
          load_val_o = rand_delay_i;
        end
      end
      default: state_d = ST_DOWN_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DOWN_WAIT;
      poll_q  <= 1'b0;
      link_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      poll_q  <= poll_d;
      link_q  <= link_d;
    end
  end

  assign poll_o     = poll_q;
  assign phy_rst_o  = (state_q == ST_DOWN_RESET);
  assign role_req_o = (state_q == ST_RESTORE_ROLE);
  assign link_ok_o  = link_q;

  AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_rst_o |=> !phy_rst_o);  // R4
  AST_RST_AT_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_rst_o |-> poll_o && !link_ok_o);  // R4
  AST_UP_NO_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_o && link_ok_o |-> !phy_rst_o);  // R4
  AST_ROLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    role_req_o && !role_done_i |=> role_req_o);  // R6
  AST_ROLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    role_req_o && role_done_i |=> !role_req_o && !poll_o);  // R6
  AST_LINK_AT_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poll_o |-> $stable(link_ok_o));  // R7
  AST_POLL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_o && (UP_TICKS > 1) |=> !poll_o);  // R8
  AST_NO_POLL_IN_RECOVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    role_req_o |-> !poll_o);  // R8
endmodule

// File: rtl/lrs_link_supervisor.sv
module lrs_link_supervisor
  import lrs_pkg::*;
#(
  parameter int UP_MS       = 1000,
  parameter int DOWN_MIN_MS = 100,
  parameter int DOWN_MAX_MS = 1000,
  parameter int MDC_MS      = 1,
  parameter int SETTLE_MS   = 600,
  parameter int RND_W       = 16,
  parameter logic [RND_W-1:0] RND_TAPS = 16'hB400,
  parameter logic [RND_W-1:0] RND_SEED = 16'hACE1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_ms_i,
  input  logic link_up_i,
  input  logic role_done_i,
  output logic phy_rst_o,
  output logic role_req_o,
  output logic poll_o,
  output logic speed_gbit_o,
  output logic duplex_full_o
);
  localparam int UP_TICKS  = (UP_MS < 1) ? 1 : UP_MS;
  localparam int MIN_TICKS = (DOWN_MIN_MS < 1) ? 1 : DOWN_MIN_MS;
  localparam int MDC_TICKS = MDC_MS + 1;
  localparam int SET_TICKS = (SETTLE_MS < 1) ? 1 : SETTLE_MS;
  localparam int TOP = lrs_max(lrs_max(UP_TICKS, lrs_max(DOWN_MAX_MS, MIN_TICKS)),
                               lrs_max(MDC_TICKS, SET_TICKS));
  localparam int CW  = $clog2(TOP + 1);

  logic [RND_W-1:0] rnd;
  logic [CW-1:0]    rand_delay;
  logic             load;
  logic [CW-1:0]    load_val;
  logic             expire;
  logic             link_ok;

  lrs_lfsr #(.W(RND_W), .TAPS(RND_TAPS), .SEED(RND_SEED)) u_lfsr (
    .clk_i, .rst_ni, .rnd_o(rnd)
  );

  lrs_delay_pick #(.RW(RND_W), .CW(CW), .MIN_MS(DOWN_MIN_MS), .MAX_MS(DOWN_MAX_MS)) u_pick (
    .clk_i, .rst_ni, .rnd_i(rnd), .delay_o(rand_delay)
  );

  lrs_tick_timer #(.CW(CW), .RST_VAL(MIN_TICKS)) u_timer (
    .clk_i, .rst_ni, .tick_i(tick_ms_i), .load_i(load), .val_i(load_val), .expire_o(expire)
  );

  lrs_fsm #(.CW(CW), .UP_TICKS(UP_TICKS), .MDC_TICKS(MDC_TICKS), .SET_TICKS(SET_TICKS)) u_fsm (
    .clk_i, .rst_ni,
    .expire_i(expire), .link_up_i, .role_done_i, .rand_delay_i(rand_delay),
    .load_o(load), .load_val_o(load_val),
    .poll_o, .phy_rst_o, .role_req_o, .link_ok_o(link_ok)
  );

  assign speed_gbit_o  = link_ok;
  assign duplex_full_o = link_ok;

  AST_SPEED_DUPLEX_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speed_gbit_o == duplex_full_o);  // R7
endmodule

// File: tb/sim_lrs_link_supervisor.sv
module sim_lrs_link_supervisor;
  localparam int UP = 30, MINV = 5, MAXV = 25, MDC = 1, SET = 12;
  localparam int NCYC = 50000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 1'b0, link = 1'b1, rdone = 1'b0;
  logic phy_rst, role_req, poll, spd, dpx;

  always #2 clk = ~clk;

  lrs_link_supervisor #(.UP_MS(UP), .DOWN_MIN_MS(MINV), .DOWN_MAX_MS(MAXV),
                        .MDC_MS(MDC), .SETTLE_MS(SET)) u0 (
    .clk_i(clk), .rst_ni, .tick_ms_i(tick), .link_up_i(link), .role_done_i(rdone),
    .phy_rst_o(phy_rst), .role_req_o(role_req), .poll_o(poll),
    .speed_gbit_o(spd), .duplex_full_o(dpx)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int tk = 0, mode = 0, min_d = 1 << 30, max_d = -1, n_down = 0, idle = 0;
  bit p_link = 1'b1, p_rd = 1'b0, p_rr = 1'b0, p_poll = 1'b0, p_rst = 1'b0, exp_link = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit in_range(input int v);
    return v >= MINV && v <= MAXV;
  endfunction

  // monitor: outputs reflect the last edge, inputs are those for the next edge
  always @(negedge clk) begin
    if (!rst_ni) begin
      tk = 0; mode = 0; exp_link = 1'b0;
    end else begin
      bit skip;
      skip = 1'b0;
      idle++;
      if (poll) begin
        idle = 0;
        case (mode)
          0: chk(tk == MINV, "R3 first poll delay", tk, MINV);
          1: chk(tk == UP, "R1 up poll delay", tk, UP);
          2: begin
            chk(in_range(tk), "R2 down poll delay", tk, MINV);
            n_down++;
            if (tk < min_d) min_d = tk;
            if (tk > max_d) max_d = tk;
          end
          default: chk(1'b0, "R8 poll during recovery", 1, 0);
        endcase
        chk(spd == p_link && dpx == p_link, "R7 status at poll", spd, p_link);
        chk(phy_rst == !p_link, "R4 reset on down poll", phy_rst, !p_link);
        exp_link = p_link;
        mode = p_link ? 1 : 3;
        tk = 0;
        if (phy_rst) skip = 1'b1;
      end else begin
        if (phy_rst) chk(1'b0, "R4 reset without poll", 1, 0);
        if (link != exp_link) chk(spd == exp_link, "R7 change ignored", spd, exp_link);
      end
      if (p_poll && poll) chk(1'b0, "R8 poll width", 2, 1);
      if (p_rst && phy_rst) chk(1'b0, "R4 reset width", 2, 1);
      if (role_req && !p_rr) chk(tk == MDC + 1 + SET, "R5 settle ticks", tk, MDC + 1 + SET);
      if (p_rr) begin
        if (role_req) chk(!p_rd, "R6 request held", p_rd, 0);
        else          chk(p_rd, "R6 request drop", p_rd, 1);
      end
      if (role_req && rdone) begin
        tk = 0; mode = 2; skip = 1'b1; idle = 0;
      end
      if (!skip && tick) tk++;
      if (idle > 5000) begin
        chk(1'b0, "R8 no poll", idle, 0);
        idle = 0;
      end
      p_link = link; p_rd = rdone; p_rr = role_req; p_poll = poll; p_rst = phy_rst;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!poll, "R9 reset poll", poll, 0);
    chk(!phy_rst, "R9 reset phy_rst", phy_rst, 0);
    chk(!role_req, "R9 reset role_req", role_req, 0);
    chk(!spd, "R9 reset speed", spd, 0);
    chk(!dpx, "R9 reset duplex", dpx, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk); #1;
      tick  = ($urandom % 3) == 0;
      rdone = ($urandom % 4) == 0;
      if (c < 3000)       link = 1'b1;
      else if (c < 40000) begin if (($urandom % 150) == 0) link = ~link; end
      else                link = 1'b0;
      if (c >= 46000 && c < 46200) rdone = 1'b1;  // done held high: accepted at once
    end
    @(negedge clk);
    chk(n_down > 5, "R2 down polls seen", n_down, 6);
    chk(max_d > min_d, "R2 delays vary", max_d, min_d + 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule